// File: doc/BRIEF.md
# Vector Layer Normalization Unit

This unit normalises one vector of signed 8-bit samples. A `start` pulse arms it. It then takes the samples one at a time through a valid/ready input stream and keeps them in an internal buffer. While they arrive it accumulates their sum. It then works out the mean, makes a second pass over the buffer to get the variance, and takes an integer square root to reach the standard deviation. A third pass streams out each sample's distance from the mean divided by the standard deviation. Each result is a signed fixed-point byte with four integer bits and four fraction bits.

The vector length is a power of two, so both averages are arithmetic right shifts. The square root and every per-element division run as small bit-serial engines. This keeps the datapath narrow, and a full vector takes several cycles per element. Both stream interfaces accept back-pressure. A sample transfers only in a cycle where both valid and ready are high. `in_ready` is high only while the unit still needs input samples. Once `out_valid` rises, it stays high and `out_data` stays frozen until the consumer raises `out_ready`. A consumer may hold `out_ready` low for any number of cycles.

Top module: `lnorm_unit`

## Requirements
- R1: After a `start` pulse in the idle state, `in_ready` stays high until exactly N samples have been accepted, and it is low at every other time, including the cycle after the Nth acceptance.
- R2: The mean is the sum of the N samples divided by N and rounded toward negative infinity; for example, a sum of -63 with N = 64 gives a mean of -1.
- R3: The variance is the sum over all samples of (sample - mean)^2, divided by N and rounded down; the standard deviation is the floor of its square root.
- R4: A standard deviation of zero is replaced by 1, so a constant vector yields all-zero outputs.
- R5: Output k, counted from 0 in input order, is (sample_k - mean) * 16 / sd, truncated toward zero, as a two's-complement byte read with 4 fraction bits.
- R6: A result above 127 is delivered as 127 (0x7F), and a result below -128 is delivered as -128 (0x80).
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value into the next cycle.
- R8: `done` is high for exactly one cycle, the cycle after the Nth output handshake, and in that cycle `out_valid` and `in_ready` are low. A `start` that arrives while a vector is in progress is ignored.
- R9: During and directly after reset, `in_ready`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new vector when the unit is idle |
| done | output | 1 | One-cycle pulse after the last output transfer |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Unit accepts an input sample this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Normalised result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | DW | Signed Q4.4 normalised result |

## Verification
The bench builds the unit with N = 64 and DW = 8 instead of the default length of 256. This keeps each vector to about a thousand cycles. It also puts saturation within reach: with 64 samples, a lone outlier can sit more than eight standard deviations from the mean, which cannot happen with 16 samples. At this size the bench can run a vector whose negative sum is not a multiple of N, a constant vector that forces the zero-deviation clamp, and single-outlier vectors that clip at both ends. All of these run under irregular input gaps and output stalls.

// File: rtl/lnorm_pkg.sv
package lnorm_pkg;

  // Pass sequence of the normaliser
  typedef enum logic [2:0] {
    ST_IDLE,    // waiting for start
    ST_LOAD,    // capturing samples, accumulating the sum
    ST_SPREAD,  // re-reading buffer, accumulating squared deviations
    ST_ROOT,    // integer square root in progress
    ST_ISSUE,   // launching one element division
    ST_DIVIDE,  // division in progress
    ST_EMIT     // result offered on the output stream
  } lnorm_state_e;

endpackage

// File: rtl/lnorm_isqrt.sv
// Bit-serial restoring integer square root: one result bit per cycle.
module lnorm_isqrt #(
  parameter int IW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IW-1:0]   radicand,
  output logic            done,
  output logic [IW/2-1:0] root
);
  localparam int OW = IW / 2;
  localparam int RW = OW + 3;
  localparam int CW = $clog2(OW + 1);

  logic [IW-1:0] rad_q;
  logic [RW-1:0] rem_q;
  logic [OW-1:0] root_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  logic [RW-1:0] shifted;
  logic [RW-1:0] trial;
  logic          fits;

  assign shifted = {rem_q[RW-3:0], rad_q[IW-1:IW-2]};
  assign trial   = {1'b0, root_q, 2'b01};
  assign fits    = shifted >= trial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rad_q  <= radicand;
        rem_q  <= '0;
        root_q <= '0;
        cnt_q  <= CW'(OW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rad_q  <= rad_q << 2;
        rem_q  <= fits ? (shifted - trial) : shifted;
        root_q <= {root_q[OW-2:0], fits};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign root = root_q;

endmodule

// File: rtl/lnorm_udiv.sv
// Sequential restoring unsigned divider: one quotient bit per cycle.
module lnorm_udiv #(
  parameter int NW  = 12,
  parameter int DVW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic           done,
  output logic [NW-1:0]  quotient
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0]  quo_q;
  logic [DVW-1:0] rem_q;
  logic [DVW-1:0] dvs_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q;
  logic           done_q;

  logic [DVW:0] trial;
  logic [DVW:0] diff;
  logic         ge;

  assign trial = {rem_q, quo_q[NW-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign ge    = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        quo_q  <= dividend;
        rem_q  <= '0;
        dvs_q  <= divisor;
        cnt_q  <= CW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= ge ? diff[DVW-1:0] : trial[DVW-1:0];
        quo_q  <= {quo_q[NW-2:0], ge};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

endmodule

// File: rtl/lnorm_unit.sv
module lnorm_unit
  import lnorm_pkg::*;
#(
  parameter int N    = 256,
  parameter int DW   = 8,
  parameter int FRAC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int AW     = $clog2(N);
  localparam int SUMW   = DW + AW;
  localparam int SQW    = 2 * DW;
  localparam int SQSUMW = SQW + AW;
  localparam int NW     = DW + FRAC;
  localparam int MAXPOS = (1 << (DW - 1)) - 1;

  lnorm_state_e state_q;

  logic [DW-1:0]          mem [N];
  logic [AW-1:0]          idx_q;
  logic signed [SUMW-1:0] sum_q;
  logic signed [DW-1:0]   mean_q;
  logic [SQSUMW-1:0]      sqsum_q;
  logic [DW-1:0]          sd_q;
  logic                   neg_q;
  logic [DW-1:0]          out_q;
  logic                   out_valid_q;
  logic                   done_q;

  // sample path
  logic signed [SUMW-1:0] sum_nxt;
  logic signed [SUMW-1:0] mean_full;
  logic                   take_in;
  logic                   last_idx;

  assign take_in   = (state_q == ST_LOAD) && in_valid;
  assign last_idx  = idx_q == AW'(N - 1);
  assign sum_nxt   = sum_q + {{AW{in_data[DW-1]}}, in_data};
  assign mean_full = sum_nxt >>> AW;

  // deviation of the buffered element at idx_q
  logic [DW-1:0]        rd_word;
  logic signed [DW:0]   dev;
  logic [DW:0]          dev_neg;
  logic [DW-1:0]        dev_abs;
  logic [SQW-1:0]       dev_sq;
  logic [SQSUMW-1:0]    sqsum_nxt;
  logic [SQW-1:0]       variance;

  assign rd_word   = mem[idx_q];
  assign dev       = {rd_word[DW-1], rd_word} - {mean_q[DW-1], mean_q};
  assign dev_neg   = -dev;
  assign dev_abs   = dev[DW] ? dev_neg[DW-1:0] : dev[DW-1:0];
  assign dev_sq    = {{DW{1'b0}}, dev_abs} * {{DW{1'b0}}, dev_abs};
  assign sqsum_nxt = sqsum_q + {{AW{1'b0}}, dev_sq};
  assign variance  = sqsum_nxt[SQSUMW-1:AW];

  // square root engine
  logic          root_start;
  logic          root_done;
  logic [DW-1:0] root_val;

  assign root_start = (state_q == ST_SPREAD) && last_idx;

  lnorm_isqrt #(.IW(SQW)) u_root (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (root_start),
    .radicand (variance),
    .done     (root_done),
    .root     (root_val)
  );

  // element divider
  logic          div_start;
  logic          div_done;
  logic [NW-1:0] div_num;
  logic [NW-1:0] quo;
  logic [NW-1:0] quo_neg;
  logic [DW-1:0] result;

  assign div_start = state_q == ST_ISSUE;
  assign div_num   = {dev_abs, {FRAC{1'b0}}};
  assign quo_neg   = -quo;

  lnorm_udiv #(.NW(NW), .DVW(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_num),
    .divisor  (sd_q),
    .done     (div_done),
    .quotient (quo)
  );

  // sign restore and clipping
  always_comb begin
    if (!neg_q) begin
      result = (quo > NW'(MAXPOS)) ? {1'b0, {(DW-1){1'b1}}} : quo[DW-1:0];
    end else begin
      result = (quo > NW'(MAXPOS + 1)) ? {1'b1, {(DW-1){1'b0}}} : quo_neg[DW-1:0];
    end
  end

  // sample buffer
  always_ff @(posedge clk) begin
    if (take_in) mem[idx_q] <= in_data;
  end

  // pass sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      sum_q       <= '0;
      mean_q      <= '0;
      sqsum_q     <= '0;
      sd_q        <= '0;
      neg_q       <= 1'b0;
      out_q       <= '0;
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            idx_q   <= '0;
            sum_q   <= '0;
            sqsum_q <= '0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (in_valid) begin
            sum_q <= sum_nxt;
            idx_q <= idx_q + 1'b1;
            if (last_idx) begin
              mean_q  <= mean_full[DW-1:0];
              state_q <= ST_SPREAD;
            end
          end
        end
        ST_SPREAD: begin
          sqsum_q <= sqsum_nxt;
          idx_q   <= idx_q + 1'b1;
          if (last_idx) state_q <= ST_ROOT;
        end
        ST_ROOT: begin
          if (root_done) begin
            sd_q    <= (root_val == '0) ? DW'(1) : root_val;
            idx_q   <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          neg_q   <= dev[DW];
          state_q <= ST_DIVIDE;
        end
        ST_DIVIDE: begin
          if (div_done) begin
            out_q       <= result;
            out_valid_q <= 1'b1;
            state_q     <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            out_valid_q <= 1'b0;
            if (last_idx) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = state_q == ST_LOAD;
  assign out_valid = out_valid_q;
  assign out_data  = out_q;
  assign done      = done_q;

endmodule

// File: rtl/lnorm_unit_chk.sv
module lnorm_unit_chk #(
  parameter int N  = 256,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  localparam int CW = $clog2(N) + 1;

  logic [CW-1:0] in_cnt;
  logic [CW-1:0] out_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else if (done) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (in_valid && in_ready)   in_cnt  <= in_cnt + 1'b1;
      if (out_valid && out_ready) out_cnt <= out_cnt + 1'b1;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1
  input_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (in_cnt < CW'(N)));

  // R1
  stream_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R5
  output_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (out_cnt < CW'(N)));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_cnt == CW'(N) && $past(out_valid && out_ready)));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !in_ready));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind lnorm_unit lnorm_unit_chk #(.N(N), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/lnorm_unit_test.sv
module lnorm_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 64;
  localparam int DW = 8;
  localparam int WATCHDOG = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int vec [N];
  int expv [N];
  int got [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  lnorm_unit #(.N(N), .DW(DW), .FRAC(4)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      report();
    end
  end

  // Reference model written from the requirements (R2..R6)
  task automatic model();
    int s, mean, v, sd, q;
    s = 0;
    for (int i = 0; i < N; i++) s += vec[i];
    mean = (s >= 0) ? s / N : -((-s + N - 1) / N);
    v = 0;
    for (int i = 0; i < N; i++) v += (vec[i] - mean) * (vec[i] - mean);
    v = v / N;
    sd = 0;
    while ((sd + 1) * (sd + 1) <= v) sd++;
    if (sd == 0) sd = 1;
    for (int i = 0; i < N; i++) begin
      q = ((vec[i] - mean) * 16) / sd;
      if (q > 127) q = 127;
      if (q < -128) q = -128;
      expv[i] = q;
    end
  endtask

  task automatic feed(input bit gaps);
    int i = 0;
    int k = 0;
    bit v;
    while (i < N) begin
      @(negedge clk);
      k++;
      v = gaps ? ((k % 3) != 0) : 1'b1;
      in_valid = v;
      in_data  = vec[i][DW-1:0];
      if (v && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    // R1: no further input is requested once N samples are in
    check(in_ready == 1'b0, "R1 in_ready after N", int'(in_ready), 0);
  endtask

  task automatic collect(input bit bp, input bit mid_start, input string tag);
    int j = 0;
    int k = 0;
    bit rdy;
    bit prev_stall = 1'b0;
    logic [DW-1:0] prev_data = '0;
    bit pulsed = 1'b0;
    while (j < N) begin
      @(negedge clk);
      k++;
      if (start) begin
        start = 1'b0;
        // R8: a start during output is ignored
        check(in_ready == 1'b0, "R8 start ignored", int'(in_ready), 0);
      end
      if (prev_stall) begin
        // R7: held result while stalled
        check(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
        check(out_data == prev_data, "R7 data held", int'(out_data), int'(prev_data));
      end
      if (mid_start && !pulsed && j == 3) begin
        start  = 1'b1;
        pulsed = 1'b1;
      end
      rdy = bp ? (((k * 7) % 5) < 2) : 1'b1;
      out_ready = rdy;
      prev_stall = out_valid && !rdy;
      prev_data  = out_data;
      if (out_valid && rdy) begin
        got[j] = int'($signed(out_data));
        check(got[j] == expv[j], tag, got[j], expv[j]);
        j++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    start = 1'b0;
    // R8: done pulse timing
    check(done == 1'b1, "R8 done after last", int'(done), 1);
    check(out_valid == 1'b0, "R8 out_valid low at done", int'(out_valid), 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
  endtask

  task automatic run_vector(input bit gaps, input bit bp, input bit mid_start, input string tag);
    model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(in_ready == 1'b1, "R1 in_ready after start", int'(in_ready), 1);
    fork
      feed(gaps);
      collect(bp, mid_start, tag);
    join
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R9 in_ready in reset", int'(in_ready), 0);
    check(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    check(done == 1'b0, "R9 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0 && out_valid == 1'b0 && done == 1'b0,
          "R9 idle after reset", int'(in_ready) + int'(out_valid) + int'(done), 0);
    // R8: nothing happens without start
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R8 idle without start", int'(in_ready), 0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < N; i++) vec[i] = i * 4 - 128;
    run_vector(1'b0, 1'b0, 1'b0, "R5 ramp");
  endtask

  task automatic t_floor_mean();
    for (int i = 0; i < N; i++) vec[i] = -1;
    vec[0] = 0;
    run_vector(1'b0, 1'b0, 1'b0, "R2 floor mean");
    // R2/R4: mean -1, variance 0 clamped to sd 1, so element 0 gives 1.0 = 16
    check(got[0] == 16, "R2 R4 element0", got[0], 16);
    check(got[1] == 0, "R2 element1", got[1], 0);
  endtask

  task automatic t_constant();
    for (int i = 0; i < N; i++) vec[i] = 50;
    run_vector(1'b1, 1'b0, 1'b0, "R4 constant");
    check(got[N-1] == 0, "R4 constant last", got[N-1], 0);
  endtask

  task automatic t_sat_pos();
    for (int i = 0; i < N; i++) vec[i] = -128;
    vec[0] = 127;
    run_vector(1'b0, 1'b1, 1'b0, "R6 positive clip");
    check(got[0] == 127, "R6 positive clip value", got[0], 127);
  endtask

  task automatic t_sat_neg();
    for (int i = 0; i < N; i++) vec[i] = 127;
    vec[0] = -128;
    run_vector(1'b0, 1'b0, 1'b0, "R6 negative clip");
    check(got[0] == -128, "R6 negative clip value", got[0], -128);
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < N; i++) vec[i] = ((i * 37 + 11) % 256) - 128;
    run_vector(1'b1, 1'b1, 1'b0, "R7 R3 mixed stalled");
  endtask

  task automatic t_busy_start();
    for (int i = 0; i < N; i++) vec[i] = (i % 9) * 3 - 12;
    run_vector(1'b0, 1'b1, 1'b1, "R8 R3 busy start");
  endtask

  initial begin
    t_reset();
    t_ramp();
    t_floor_mean();
    t_constant();
    t_sat_pos();
    t_sat_neg();
    t_backpressure();
    t_busy_start();
    t_ramp();
    report();
  end

endmodule